// File: doc/BRIEF.md
# Column-Serial AES-128 Block Encryptor

This block encrypts one 128-bit block under a 128-bit key and works on one 32-bit state column per clock. Its round datapath holds four byte-substitution units, then a column-mixing unit, then the round-key XOR. Round keys are derived one word per clock next to the column being processed, so no expanded key schedule is ever stored.

A request is a one-cycle `start_i` pulse while the block is idle. The key is taken on that edge. The plaintext is taken over the next four clocks: each clock writes one plaintext column, already XORed with the matching cipher-key word, into the state register. Ten rounds of four clocks each follow. Each round reads the state register and writes the output register column by column. When a round completes, the state register takes a copy of its result.

The state register and the output register each have their own enable, set by the current phase. The output register stays frozen while data is loading, and neither register moves while the block is idle.

Top module: `aes_col_enc`

## Requirements
- R1: The ciphertext on `cipher_o` is the AES-128 encryption of the plaintext under the key. In all three buses, byte 0 of the block is bits [127:120], and state column c (row bytes 0..3) is bits [127-32c -: 32]. All ten rounds substitute bytes, shift rows and add the round key. Rounds one to nine also mix columns, and the tenth round does not.
- R2: `done_o` is high for exactly one cycle, directly after the 44th rising edge that follows the edge on which a start was accepted. `busy_o` is high from the edge after acceptance until that same 44th edge, and it is low while `done_o` is high.
- R3: A start pulse while `busy_o` is high is ignored and does not change the running result. A start given in the cycle where `done_o` is high is accepted.
- R4: `key_i` is sampled only on the start edge. `plain_i` is sampled only on the four following edges (column 0 first). Changes to either input outside those edges do not affect the result.
- R5: During the four loading clocks after a start, `cipher_o` keeps the previous result.
- R6: While idle with no start, `cipher_o` holds its last value whatever `plain_i` and `key_i` do.
- R7: After reset, `busy_o` and `done_o` are 0 and `cipher_o` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, accepted while idle |
| plain_i | input | 128 | Plaintext block, read during the four loading clocks |
| key_i | input | 128 | Cipher key, read on the start edge |
| busy_o | output | 1 | Encryption in progress |
| done_o | output | 1 | One-cycle pulse when the result is ready |
| cipher_o | output | 128 | Ciphertext, held until the next round phase |

## Verification
The checker covers these rules on every cycle:
- the done pulse is one cycle wide, never overlaps busy, and comes exactly 44 edges after acceptance;
- busy rises after an accepted start;
- the output register is frozen throughout loading;
- both data registers stay still while idle.

The cryptographic result itself can only be shown by the bench scenarios. These include two published test vectors, random blocks compared against a behavioural model, and inputs disturbed outside their sampling windows. A stray start during busy, and a start issued in the done cycle, also have to be exercised by stimulus.

// File: rtl/aes_col_pkg.sv
package aes_col_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned NROW   = 4;
    localparam int unsigned NCOL   = 4;
    localparam int unsigned NR     = 10;
    localparam int unsigned WORD_W = NROW * BYTE_W;
    localparam int unsigned BLK_W  = NCOL * WORD_W;
    localparam int unsigned COL_W  = $clog2(NCOL);
    localparam int unsigned RND_W  = $clog2(NR + 1);

    typedef logic [BYTE_W-1:0]              byte_t;
    typedef logic [0:NROW-1][BYTE_W-1:0]    word_t;
    typedef logic [0:NCOL-1][0:NROW-1][BYTE_W-1:0] blk_t;

    typedef enum logic [1:0] {PH_IDLE, PH_LOAD, PH_ROUND} phase_e;

    typedef struct packed {
        phase_e           phase;
        logic [COL_W-1:0] col;
        logic [RND_W-1:0] rnd;
        byte_t            rcon;
        logic             done;
        blk_t             st;
        blk_t             out;
        blk_t             key;
    } regs_t;

    function automatic byte_t xtime(input byte_t a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic byte_t gf_mul(input byte_t a, input byte_t b);
        byte_t acc = '0;
        byte_t sh  = a;
        for (int i = 0; i < BYTE_W; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = xtime(sh);
        end
        return acc;
    endfunction

endpackage

// File: rtl/aes_col_sbox.sv
module aes_col_sbox
    import aes_col_pkg::*;
(
    input  byte_t a_i,
    output byte_t s_o
);
    byte_t p2, p3, p6, p7, p14, p15, p30, p31, p62, p63, p126, p127, inv;

    // inverse as a^254 through a square-and-multiply chain (0 maps to 0)
    always_comb begin
        p2   = gf_mul(a_i, a_i);
        p3   = gf_mul(p2, a_i);
        p6   = gf_mul(p3, p3);
        p7   = gf_mul(p6, a_i);
        p14  = gf_mul(p7, p7);
        p15  = gf_mul(p14, a_i);
        p30  = gf_mul(p15, p15);
        p31  = gf_mul(p30, a_i);
        p62  = gf_mul(p31, p31);
        p63  = gf_mul(p62, a_i);
        p126 = gf_mul(p63, p63);
        p127 = gf_mul(p126, a_i);
        inv  = gf_mul(p127, p127);
        s_o  = inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]}
             ^ {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
    end
endmodule

// File: rtl/aes_col_mix.sv
module aes_col_mix
    import aes_col_pkg::*;
(
    input  word_t col_i,
    output word_t col_o
);
    for (genvar r = 0; r < NROW; r++) begin : gen_mix
        localparam int R1I = (r + 1) % NROW;
        localparam int R2I = (r + 2) % NROW;
        localparam int R3I = (r + 3) % NROW;
        assign col_o[r] = xtime(col_i[r]) ^ xtime(col_i[R1I]) ^ col_i[R1I]
                        ^ col_i[R2I] ^ col_i[R3I];
    end
endmodule

// File: rtl/aes_col_keystep.sv
module aes_col_keystep
    import aes_col_pkg::*;
(
    input  word_t same_i,
    input  word_t prev_i,
    input  logic  first_i,
    input  byte_t rcon_i,
    output word_t w_o
);
    word_t sub_w, mix_w;

    // rotated substitution of the previous word, used on column 0 only
    for (genvar r = 0; r < NROW; r++) begin : gen_sub
        aes_col_sbox u_sb (.a_i(prev_i[(r + 1) % NROW]), .s_o(sub_w[r]));
    end

    always_comb begin
        mix_w = sub_w;
        mix_w[0] = sub_w[0] ^ rcon_i;
        w_o = same_i ^ (first_i ? mix_w : prev_i);
    end
endmodule

// File: rtl/aes_col_enc.sv
module aes_col_enc
    import aes_col_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [BLK_W-1:0] plain_i,
    input  logic [BLK_W-1:0] key_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [BLK_W-1:0] cipher_o
);
    regs_t q, d;
    blk_t  pt_b;
    word_t sh_w, sb_w, mx_w, rk_w, col_w, ks_prev;
    logic  last_rnd, col_last, s_en, o_en;

    assign pt_b = blk_t'(plain_i);

    // row shift by byte selection, then four substitution units
    for (genvar r = 0; r < NROW; r++) begin : gen_row
        logic [COL_W-1:0] src;
        assign src     = q.col + COL_W'(r);
        assign sh_w[r] = q.st[src][r];
        aes_col_sbox u_sb (.a_i(sh_w[r]), .s_o(sb_w[r]));
    end

    aes_col_mix u_mix (.col_i(sb_w), .col_o(mx_w));

    assign ks_prev = (q.col == '0) ? q.key[NCOL-1] : q.key[q.col - COL_W'(1)];

    aes_col_keystep u_ks (
        .same_i (q.key[q.col]),
        .prev_i (ks_prev),
        .first_i(q.col == '0),
        .rcon_i (q.rcon),
        .w_o    (rk_w)
    );

    assign last_rnd = (q.rnd == RND_W'(NR));
    assign col_last = (q.col == COL_W'(NCOL - 1));
    assign col_w    = (last_rnd ? sb_w : mx_w) ^ rk_w;
    assign s_en     = (q.phase == PH_LOAD) ||
                      ((q.phase == PH_ROUND) && col_last && !last_rnd);
    assign o_en     = (q.phase == PH_ROUND);

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    d.phase = PH_LOAD;
                    d.col   = '0;
                    d.rnd   = RND_W'(1);
                    d.rcon  = 8'h01;
                    d.key   = blk_t'(key_i);
                end
            end
            PH_LOAD: begin
                d.col = q.col + COL_W'(1);
                if (col_last) d.phase = PH_ROUND;
            end
            PH_ROUND: begin
                d.key[q.col] = rk_w;
                d.col        = q.col + COL_W'(1);
                if (col_last) begin
                    d.rcon = xtime(q.rcon);
                    if (last_rnd) begin
                        d.phase = PH_IDLE;
                        d.done  = 1'b1;
                    end else begin
                        d.rnd = q.rnd + RND_W'(1);
                    end
                end
            end
            default: d.phase = PH_IDLE;
        endcase
        // state register: written only while loading or at a round's end
        if (s_en) begin
            if (q.phase == PH_LOAD) begin
                d.st[q.col] = pt_b[q.col] ^ q.key[q.col];
            end else begin
                d.st          = q.out;
                d.st[NCOL-1]  = col_w;
            end
        end
        // output register: written only during round clocks
        if (o_en) d.out[q.col] = col_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.phase <= PH_IDLE;
        end else begin
            q <= d;
        end
    end

    assign busy_o   = (q.phase != PH_IDLE);
    assign done_o   = q.done;
    assign cipher_o = q.out;
endmodule

// File: rtl/aes_col_enc_chk.sv
module aes_col_enc_chk
    import aes_col_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             busy_o,
    input logic             done_o,
    input logic [BLK_W-1:0] cipher_o,
    input phase_e           phase_i,
    input blk_t             state_i
);
    localparam int unsigned LAT = NCOL + NR * NCOL;

    int unsigned edges_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  edges_q <= 0;
        else if (start_i && !busy_o) edges_q <= 0;
        else if (busy_o)             edges_q <= edges_q + 1;
    end

    a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r2_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (edges_q == LAT));

    a_r2_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    a_r5_out_quiet_load: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_i == PH_LOAD) |=> $stable(cipher_o));

    a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> ($stable(cipher_o) && $stable(state_i)));
endmodule

bind aes_col_enc aes_col_enc_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .cipher_o(cipher_o),
    .phase_i (q.phase),
    .state_i (q.st)
);

// File: tb/tb_aes_col_enc.sv
`timescale 1ns/1ps
module tb_aes_col_enc;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [127:0] plain_i = '0;
    logic [127:0] key_i = '0;
    logic         busy_o, done_o;
    logic [127:0] cipher_o;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    aes_col_enc dut (.*);

    // ---------------- behavioural reference ----------------
    logic [7:0] sbox_t [256];

    function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] p = 0;
        logic [7:0] x = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) p ^= x;
            x = x[7] ? ((x << 1) ^ 8'h1b) : (x << 1);
        end
        return p;
    endfunction

    function automatic logic [127:0] ref_enc(input logic [127:0] pt, input logic [127:0] key);
        logic [7:0] s [16];
        logic [7:0] n [16];
        logic [7:0] w [176];
        logic [7:0] t [4];
        logic [7:0] rc = 8'h01;
        logic [7:0] tmp;
        logic [127:0] res;
        for (int i = 0; i < 16; i++) begin
            s[i] = pt[127-8*i -: 8];
            w[i] = key[127-8*i -: 8];
        end
        for (int i = 16; i < 176; i += 4) begin
            for (int j = 0; j < 4; j++) t[j] = w[i-4+j];
            if (i % 16 == 0) begin
                tmp = t[0]; t[0] = t[1]; t[1] = t[2]; t[2] = t[3]; t[3] = tmp;
                for (int j = 0; j < 4; j++) t[j] = sbox_t[t[j]];
                t[0] ^= rc;
                rc = gmul(rc, 8'h02);
            end
            for (int j = 0; j < 4; j++) w[i+j] = w[i-16+j] ^ t[j];
        end
        for (int i = 0; i < 16; i++) s[i] ^= w[i];
        for (int rd = 1; rd <= 10; rd++) begin
            for (int c = 0; c < 4; c++)
                for (int r = 0; r < 4; r++)
                    n[4*c+r] = sbox_t[s[4*((c+r)%4)+r]];
            for (int c = 0; c < 4; c++) begin
                if (rd < 10) begin
                    for (int r = 0; r < 4; r++)
                        s[4*c+r] = gmul(n[4*c+r], 2) ^ gmul(n[4*c+(r+1)%4], 3)
                                 ^ n[4*c+(r+2)%4] ^ n[4*c+(r+3)%4];
                end else begin
                    for (int r = 0; r < 4; r++) s[4*c+r] = n[4*c+r];
                end
            end
            for (int i = 0; i < 16; i++) s[i] ^= w[16*rd+i];
        end
        for (int i = 0; i < 16; i++) res[127-8*i -: 8] = s[i];
        return res;
    endfunction

    initial begin
        for (int x = 0; x < 256; x++) begin
            logic [7:0] inv = 0;
            logic [7:0] b;
            for (int y = 1; y < 256; y++)
                if (gmul(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
            b = inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]}
              ^ {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
            sbox_t[x] = b;
        end
    end

    // cycle model: busy/done/result per edge
    bit           busy_m = 0;
    bit           done_m = 0;
    int           cnt_m = 0;
    logic [127:0] pt_m, key_m;
    logic [127:0] cipher_m = '0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_m = 0; done_m = 0; cnt_m = 0; cipher_m = '0;
        end else begin
            done_m = 0;
            if (busy_m) begin
                cnt_m++;
                if (cnt_m == 44) begin
                    busy_m = 0;
                    done_m = 1;
                    cipher_m = ref_enc(pt_m, key_m);
                end
            end else if (start_i) begin
                busy_m = 1; cnt_m = 0; pt_m = plain_i; key_m = key_i;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(busy_o == busy_m, "R2 busy", 128'(busy_o), 128'(busy_m));
            chk(done_o == done_m, "R2 done", 128'(done_o), 128'(done_m));
            if (done_m)
                chk(cipher_o == cipher_m, "R1 result", cipher_o, cipher_m);
            else if (busy_m && cnt_m <= 4)
                chk(cipher_o == cipher_m, "R5 load hold", cipher_o, cipher_m);
            else if (!busy_m)
                chk(cipher_o == cipher_m, "R6 idle hold", cipher_o, cipher_m);
        end
    end

    // called at a negedge; returns at the negedge where done_o is seen
    task automatic run_op(input logic [127:0] pt, input logic [127:0] k,
                          input bit disturb, input bit stray, output int lat);
        start_i = 1; plain_i = pt; key_i = k;
        lat = -1;
        forever begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            if (lat == 0) begin
                start_i = 0;
                if (disturb) key_i = {$urandom, $urandom, $urandom, $urandom};
            end
            if (disturb && lat == 4) plain_i = {$urandom, $urandom, $urandom, $urandom};
            if (stray && lat == 10) begin
                start_i = 1; plain_i = ~pt; key_i = ~k;
            end
            if (stray && lat == 11) begin
                start_i = 0; plain_i = pt; key_i = k;
            end
            if (done_o || lat > 100) break;
        end
    endtask

    initial begin
        int lat;
        logic [127:0] pt, k, first_res;
        repeat (3) @(negedge clk);
        // R7 reset state
        chk(busy_o == 0 && done_o == 0, "R7 reset flags", 128'({busy_o, done_o}), 128'd0);
        chk(cipher_o == '0, "R7 reset data", cipher_o, '0);
        rst_n = 1;
        @(negedge clk);

        // R1 and R2 with the published vectors
        run_op(128'h00112233445566778899aabbccddeeff, 128'h000102030405060708090a0b0c0d0e0f, 0, 0, lat);
        chk(lat == 44, "R2 latency", 128'(lat), 128'd44);
        chk(cipher_o == 128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R1 vector A", cipher_o,
            128'h69c4e0d86a7b0430d8cdb78070b4c55a);
        @(negedge clk);
        chk(done_o == 0, "R2 single pulse", 128'(done_o), 128'd0);
        run_op(128'h3243f6a8885a308d313198a2e0370734, 128'h2b7e151628aed2a6abf7158809cf4f3c, 0, 0, lat);
        chk(cipher_o == 128'h3925841d02dc09fbdc118597196a0b32, "R1 vector B", cipher_o,
            128'h3925841d02dc09fbdc118597196a0b32);

        // R3 back-to-back start in the done cycle, then a stray start while busy
        pt = {$urandom, $urandom, $urandom, $urandom};
        k  = {$urandom, $urandom, $urandom, $urandom};
        run_op(pt, k, 0, 1, lat);
        chk(lat == 44, "R3 back-to-back latency", 128'(lat), 128'd44);
        chk(cipher_o == ref_enc(pt, k), "R3 stray start ignored", cipher_o, ref_enc(pt, k));
        first_res = cipher_o;

        // R6 idle with moving inputs
        for (int i = 0; i < 8; i++) begin
            plain_i = {$urandom, $urandom, $urandom, $urandom};
            key_i = {$urandom, $urandom, $urandom, $urandom};
            @(negedge clk);
        end
        chk(cipher_o == first_res, "R6 idle result kept", cipher_o, first_res);

        // R4 inputs disturbed outside their sampling edges
        for (int i = 0; i < 4; i++) begin
            pt = {$urandom, $urandom, $urandom, $urandom};
            k  = {$urandom, $urandom, $urandom, $urandom};
            run_op(pt, k, 1, 0, lat);
            chk(cipher_o == ref_enc(pt, k), "R4 sampling window", cipher_o, ref_enc(pt, k));
            repeat (i) @(negedge clk);
        end

        // random blocks, R1
        for (int i = 0; i < 6; i++) begin
            pt = {$urandom, $urandom, $urandom, $urandom};
            k  = {$urandom, $urandom, $urandom, $urandom};
            run_op(pt, k, 0, 0, lat);
            chk(cipher_o == ref_enc(pt, k), "R1 random", cipher_o, ref_enc(pt, k));
        end
        repeat (3) @(negedge clk);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule